// File: doc/BRIEF.md
# Transmit Heartbeat Check Monitor

After a serial Ethernet transceiver finishes sending a frame, it is expected to raise its collision line briefly as a sign that its collision detector still works. This monitor sits next to the transmit path of a MAC. It notices when transmit enable drops and then listens to the collision input for a fixed number of clock cycles. When that listening period ends, it reports one status result for the packet that just went out. The result says whether the heartbeat was missing, and the MAC folds that flag into the packet's transmit status word.

A single control input switches the check off. The input is active-high, so writing 0 enables the check. A collision seen while the frame is still being sent is not a heartbeat, and this block does not count it as one. If the next frame starts before the listening period is over, the monitor stops listening at that point and reports a result based on what it has seen so far. The window length is the parameter `WIN_LEN` and must be at least 2.

Top module: `sqe_heartbeat_mon`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `stat_valid` and `hb_fail` are both 0.
- R2: A window opens at the first rising clock edge where `tx_en` is sampled low after being sampled high. It takes `WIN_LEN` consecutive samples of `col_in`, that edge included. `stat_valid` is 1 for exactly one cycle, starting on the edge after the last sample. A sample taken one cycle after the window does not count.
- R3: If `col_in` is sampled 1 at any sample inside the window, the strobe carries `hb_fail` = 0. A one-cycle pulse is enough.
- R4: If no sample in the window sees `col_in` = 1 and `sqe_off` = 0, the strobe carries `hb_fail` = 1.
- R5: If `sqe_off` = 1 when the window closes, the strobe carries `hb_fail` = 0, whether or not a pulse was seen.
- R6: `col_in` sampled while `tx_en` is 1 never satisfies the check, and it leaves the result of the next window unchanged.
- R7: If `tx_en` is sampled 1 while a window is open, that window closes on that edge. The strobe follows on the next cycle, and its result uses only the samples taken before that edge.
- R8: `hb_fail` is 0 on every cycle where `stat_valid` is 0. Each transmission produces exactly one strobe, and no strobe occurs without a preceding transmission.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable from the MAC transmit path |
| col_in | input | 1 | Collision line from the transceiver |
| sqe_off | input | 1 | Heartbeat check disable; 0 enables the check |
| stat_valid | output | 1 | One-cycle strobe carrying the per-packet result |
| hb_fail | output | 1 | Heartbeat missing for the packet, valid with the strobe |

## Verification
The bench builds the monitor with `WIN_LEN` = 8. With this small value, the bench can place a pulse on the last sample of the window and one cycle beyond it within a few cycles. It can also restart transmission partway through a window and run many back-to-back packets quickly. The default of 64 would follow the same paths, only over longer waits.

// File: rtl/sqe_pkg.sv
package sqe_pkg;

  // Result handed to the transmit status word
  typedef struct packed {
    logic valid;
    logic fail;
  } sqe_stat_t;

  // True when taking one more sample fills a window of len samples
  function automatic logic window_full(input int unsigned taken,
                                       input int unsigned len);
    return (taken + 1) >= len;
  endfunction

  // Heartbeat verdict: missing pulse is a failure only when checking is on
  function automatic logic verdict(input logic pulse_seen, input logic off);
    return !off && !pulse_seen;
  endfunction

endpackage

// File: rtl/sqe_edge.sv
module sqe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  output logic fall_evt,
  output logic tx_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_en;
  end

  // End of transmission: previous sample high, present sample low
  assign fall_evt = tx_q && !tx_en;

endmodule

// File: rtl/sqe_window.sv
module sqe_window #(
  parameter int unsigned WIN_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic fall_evt,
  output logic sample_evt,
  output logic close_evt,
  output logic early_evt,
  output logic win_open
);
  import sqe_pkg::*;

  localparam int unsigned CW = $clog2(WIN_LEN + 1);

  logic [CW-1:0] taken_q;
  logic [CW-1:0] taken_base;
  logic          last_evt;

  assign sample_evt = (fall_evt || win_open) && !tx_en;
  assign early_evt  = win_open && tx_en;
  assign taken_base = fall_evt ? '0 : taken_q;
  assign last_evt   = sample_evt && window_full(32'(taken_base), WIN_LEN);
  assign close_evt  = early_evt || last_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      taken_q  <= '0;
    end else if (close_evt) begin
      win_open <= 1'b0;
      taken_q  <= '0;
    end else if (sample_evt) begin
      win_open <= 1'b1;
      taken_q  <= taken_base + CW'(1);
    end
  end

  // R2: a sample count never exceeds the window length
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= CW'(WIN_LEN));

  // R2: end of transmission leaves the window open on the next cycle
  p_open_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> win_open);

  // R7: a restart of transmission shuts the window
  p_early_shut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && tx_en) |=> !win_open);

endmodule

// File: rtl/sqe_capture.sv
module sqe_capture (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_evt,
  input  logic             first_evt,
  input  logic             close_evt,
  input  logic             col_in,
  input  logic             sqe_off,
  output logic             seen_q,
  output sqe_pkg::sqe_stat_t stat_q
);
  import sqe_pkg::*;

  logic seen_now;

  assign seen_now = (first_evt ? 1'b0 : seen_q) || (sample_evt && col_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      stat_q <= '0;
    end else begin
      if (sample_evt) seen_q <= seen_now;
      stat_q.valid <= close_evt;
      stat_q.fail  <= close_evt && verdict(seen_now, sqe_off);
    end
  end

  // R8: the flag is only ever raised together with the strobe
  p_fail_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q.fail |-> stat_q.valid);

  // R5: with checking switched off at close, no failure is reported
  p_disabled_no_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && sqe_off) |=> !stat_q.fail);

  // R3: a sample of the pulse at close gives a pass
  p_pulse_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && sample_evt && col_in) |=> (stat_q.valid && !stat_q.fail));

endmodule

// File: rtl/sqe_heartbeat_mon.sv
module sqe_heartbeat_mon #(
  parameter int unsigned WIN_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic col_in,
  input  logic sqe_off,
  output logic stat_valid,
  output logic hb_fail
);
  import sqe_pkg::*;

  logic      fall_evt;
  logic      tx_q;
  logic      sample_evt;
  logic      close_evt;
  logic      early_evt;
  logic      win_open;
  logic      seen_q;
  sqe_stat_t stat_q;

  sqe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .fall_evt (fall_evt),
    .tx_q     (tx_q)
  );

  sqe_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .fall_evt   (fall_evt),
    .sample_evt (sample_evt),
    .close_evt  (close_evt),
    .early_evt  (early_evt),
    .win_open   (win_open)
  );

  sqe_capture u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_evt (sample_evt),
    .first_evt  (fall_evt),
    .close_evt  (close_evt),
    .col_in     (col_in),
    .sqe_off    (sqe_off),
    .seen_q     (seen_q),
    .stat_q     (stat_q)
  );

  assign stat_valid = stat_q.valid;
  assign hb_fail    = stat_q.fail;

  // R2: the strobe lasts a single cycle (WIN_LEN of 2 or more)
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  // R7: an early close is reported on the next cycle
  p_early_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    early_evt |=> stat_valid);

  // R6: collision during transmission outside a window leaves the pulse record alone
  p_tx_col_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !win_open) |=> $stable(seen_q));

  // R8: no strobe unless a transmission ended or is being restarted
  p_strobe_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !fall_evt) |=> !stat_valid);

  // R1: registered transmit enable is low right after reset
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!stat_valid && !hb_fail && !tx_q));

endmodule

// File: tb/sim_sqe_heartbeat_mon.sv
`timescale 1ns/1ps
module sim_sqe_heartbeat_mon;
  localparam int W = 8;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic col_in = 1'b0;
  logic sqe_off = 1'b0;
  logic stat_valid;
  logic hb_fail;

  int n_total = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  string tag = "R2";

  // reference model state
  bit m_prev = 0, m_open = 0, m_seen = 0, e_valid = 0, e_fail = 0;
  int m_taken = 0;
  int fails[$];

  always #10 clk = ~clk;

  sqe_heartbeat_mon #(.WIN_LEN(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .col_in(col_in),
    .sqe_off(sqe_off), .stat_valid(stat_valid), .hb_fail(hb_fail)
  );

  task automatic check(input string req, input logic got, input logic exp,
                       input string what);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b at cycle %0d", req, what, got, exp, cyc);
    end
  endtask

  // behavioural reference: one report per transmission, built from the requirements
  always @(posedge clk) begin
    cyc++;
    e_valid = 0;
    e_fail = 0;
    if (!rst_n) begin
      m_prev = 0; m_open = 0; m_seen = 0; m_taken = 0;
    end else begin
      if (m_open && tx_en) begin
        e_valid = 1; e_fail = !sqe_off && !m_seen; m_open = 0;
      end else if (!tx_en && (m_open || m_prev)) begin
        if (!m_open) begin m_open = 1; m_taken = 0; m_seen = 0; end
        if (col_in) m_seen = 1;
        m_taken++;
        if (m_taken == W) begin
          e_valid = 1; e_fail = !sqe_off && !m_seen; m_open = 0;
        end
      end
      m_prev = tx_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag, stat_valid, e_valid, "strobe vs model");
      check(tag, hb_fail, e_fail, "flag vs model");
      if (stat_valid) fails.push_back(int'(hb_fail));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // send a frame, pulse col_in at sample k after the drop (k<0: none)
  task automatic packet(input int len, input int k, input bit col_tx);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); tx_en = 1; col_in = col_tx;
    end
    @(negedge clk); tx_en = 0; col_in = (k == 0);
    for (int i = 1; i < W + 4; i++) begin
      @(negedge clk); col_in = (i == k);
    end
    col_in = 0;
  endtask

  task automatic expect_results(input string req, input int n, input int f0, input int f1);
    check(req, 1'(fails.size() == n), 1'b1, "strobe count");
    if (fails.size() >= 1) check(req, 1'(fails[0]), 1'(f0), "first flag");
    if (n == 2 && fails.size() >= 2) check(req, 1'(fails[1]), 1'(f1), "second flag");
    fails.delete();
  endtask

  initial begin
    // R1: reset state
    #5;
    check("R1", stat_valid, 1'b0, "strobe in reset");
    check("R1", hb_fail, 1'b0, "flag in reset");
    idle(3);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    check("R1", stat_valid, 1'b0, "strobe after reset");
    idle(4);

    tag = "R3"; packet(5, 3, 0); expect_results("R3", 1, 0, 0);
    tag = "R4"; packet(4, -1, 0); expect_results("R4", 1, 1, 0);
    tag = "R6"; packet(6, -1, 1); expect_results("R6", 1, 1, 0);
    tag = "R5"; sqe_off = 1; packet(3, -1, 0); expect_results("R5", 1, 0, 0);
    packet(3, 2, 0); expect_results("R5", 1, 0, 0);
    sqe_off = 0;
    tag = "R2"; packet(2, 0, 0); expect_results("R2", 1, 0, 0);
    packet(2, W - 1, 0); expect_results("R2", 1, 0, 0);
    packet(2, W, 0); expect_results("R2", 1, 1, 0);

    // R7: restart mid-window, no pulse then with pulse
    tag = "R7";
    for (int p = 0; p < 2; p++) begin
      @(negedge clk); tx_en = 1;
      @(negedge clk); tx_en = 0;
      for (int i = 1; i < 4; i++) begin
        @(negedge clk); col_in = (p == 1 && i == 2);
      end
      @(negedge clk); col_in = 0; tx_en = 1;
      idle(2);
      @(negedge clk); tx_en = 0;
      idle(W + 3);
      expect_results("R7", 2, (p == 0) ? 1 : 0, 1);
    end

    // R8: idle with collisions and no transmission gives no strobe
    tag = "R8";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); col_in = i[0];
    end
    col_in = 0;
    expect_results("R8", 0, 0, 0);
    for (int n = 0; n < 6; n++) packet(1 + n, (n % 3 == 0) ? -1 : n, 0);
    check("R8", 1'(fails.size() == 6), 1'b1, "one strobe per frame");
    fails.delete();

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      n_total++; n_fail++;
      $display("FAIL R8 watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule